// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. The caller gives it the table base and a virtual address through a valid/ready request. The walker then issues word reads on a simple memory read port, one at a time. The first read fetches a first-level entry. That entry resolves the request as a 1 MB section, points to a second-level table, or faults. For a pointer entry, a second read fetches a second-level entry. That entry gives a 64 KB or 4 KB page, or a fault.

A successful result returns the physical address, the cacheable and bufferable flags, the 4-bit domain and the 2-bit permission code that applies. Every second-level entry holds four permission codes, one for each quarter of its page. The walker picks the code for the quarter that the virtual address falls in. A fault result names the level that failed and returns the virtual address with a zero physical address. Caching of translations and the enforcement of domains or permissions belong to the surrounding logic.

Top module: `mmu_walker`

## Requirements
- R1: The first read goes to address {ttb[31:14], va[31:20], 2'b00}. Base bits 13:0 are ignored, so the table is 16 KB aligned with 4096 word entries.
- R2: Bits 1:0 of the first-level entry set its kind: 2'b10 is a section, 2'b01 is a pointer to a second-level table, and 2'b00 or 2'b11 is a first-level fault. A section or first-level fault finishes after exactly one read, and a pointer leads to exactly one more.
- R3: A section result has pa = {entry[31:20], va[19:0]}, ap = entry[11:10], cacheable = entry[3], bufferable = entry[2] and domain = entry[8:5].
- R4: The second read goes to address {l1[31:10], va[19:12], 2'b00}, which is a 256-entry, 1 KB table.
- R5: A second-level entry with bits 1:0 = 2'b01 is a 64 KB page. Its pa is {entry[31:16], va[15:0]}, and its ap is the field at entry bits [4+2k +: 2] with k = va[15:14].
- R6: A second-level entry with bits 1:0 = 2'b10 is a 4 KB page. Its pa is {entry[31:12], va[11:0]}, and its ap is the field at entry bits [4+2k +: 2] with k = va[11:10].
- R7: A second-level entry with bits 1:0 = 2'b00 or 2'b11 gives a fault with res_fault_l2 = 1. A first-level fault gives res_fault_l2 = 0. On any fault, pa, ap, domain, cacheable and bufferable are all zero, and res_va holds the faulting address.
- R8: For a page, cacheable and bufferable come from bits 3 and 2 of the second-level entry, and the domain comes from bits 8:5 of the first-level entry.
- R9: req_ready is high only while the walker is idle. A result stays valid and unchanged until res_ready is seen, and only one memory read is in flight at a time.
- R10: When memory accepts reads at once and returns data one cycle later, res_valid rises 2 clock edges after the request is accepted for a section or first-level fault, and 4 edges after for a page or second-level fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ttb | input | 32 | Translation table base; bits 31:14 are used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_va | input | 32 | Virtual address to translate |
| mem_rd_en | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Word address of the read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Read data (descriptor) |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_fault | output | 1 | Translation faulted |
| res_fault_l2 | output | 1 | Fault came from the second level |
| res_pa | output | 32 | Physical address |
| res_cacheable | output | 1 | Cacheable attribute |
| res_bufferable | output | 1 | Bufferable attribute |
| res_domain | output | 4 | Domain number |
| res_ap | output | 2 | Access-permission code: 0 supervisor read-only, 1 supervisor read/write, 2 adds user read-only, 3 adds user read/write |
| res_va | output | 32 | Virtual address of the walk |

## Verification
The bench memory accepts every read at once and answers one cycle later. A section or first-level fault is therefore due on the second edge after the request is accepted, and a page or second-level fault on the fourth. The bench drives on the falling edge and counts falling edges from acceptance until res_valid rises. It checks that this count is exactly 2 or 4, then compares every result field with its own model of the two descriptors. It also logs each read address the memory sees and checks it against the expected table address. While the result is held, res_ready stays low for a random number of cycles and the fields are checked for stability. The bench then checks that req_ready comes back one edge after the handshake.

// File: rtl/mmu_walk_pkg.sv
// Package: shared constants and types of the translation table walker.
// Assumes the fixed 32-bit, two-level descriptor format.
package mmu_walk_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned DOM_W     = 4;
    localparam int unsigned AP_W      = 2;
    localparam int unsigned AP_SLOTS  = 4;
    localparam int unsigned AP_LSB    = 4;
    localparam int unsigned SECT_SH   = 20;
    localparam int unsigned LARGE_SH  = 16;
    localparam int unsigned SMALL_SH  = 12;

    typedef enum logic [1:0] {ST_IDLE, ST_L1_READ, ST_L2_READ, ST_DONE} walk_state_t;
    typedef enum logic [1:0] {L1_FAULT, L1_TABLE, L1_SECTION} l1_kind_t;
    typedef enum logic [1:0] {L2_FAULT, L2_LARGE, L2_SMALL} l2_kind_t;

    typedef struct packed {
        logic              fault;
        logic              fault_l2;
        logic [ADDR_W-1:0] pa;
        logic              cacheable;
        logic              bufferable;
        logic [DOM_W-1:0]  domain;
        logic [AP_W-1:0]   ap;
    } walk_result_t;
endpackage

// File: rtl/mmu_l1_decode.sv
// Module: decodes a first-level descriptor into its kind, a section
// result and the address of the second-level entry.
// Assumes desc is the word just read and va_low holds va[19:0].
module mmu_l1_decode
    import mmu_walk_pkg::*;
(
    input  logic [DATA_W-1:0]  desc,
    input  logic [SECT_SH-1:0] va_low,
    output l1_kind_t           kind,
    output walk_result_t       sect,
    output logic [ADDR_W-1:0]  l2_addr
);
    logic [1:0] unused_bits;
    assign unused_bits = {desc[9], desc[4]};

    // Classify the descriptor by its two type bits.
    always_comb begin
        unique case (desc[1:0])
            2'b01:   kind = L1_TABLE;
            2'b10:   kind = L1_SECTION;
            default: kind = L1_FAULT;
        endcase
    end

    // Build the section result and the second-level entry address.
    always_comb begin
        sect.fault      = 1'b0;
        sect.fault_l2   = 1'b0;
        sect.pa         = {desc[ADDR_W-1:SECT_SH], va_low};
        sect.cacheable  = desc[3];
        sect.bufferable = desc[2];
        sect.domain     = desc[8:5];
        sect.ap         = desc[11:10];
        l2_addr         = {desc[ADDR_W-1:10], va_low[SECT_SH-1:SMALL_SH], 2'b00};
    end
endmodule

// File: rtl/mmu_l2_decode.sv
// Module: decodes a second-level descriptor into page kind, physical
// address, attributes and the sub-page permission that applies.
// Assumes va_low holds va[15:0].
module mmu_l2_decode
    import mmu_walk_pkg::*;
(
    input  logic [DATA_W-1:0]   desc,
    input  logic [LARGE_SH-1:0] va_low,
    output l2_kind_t            kind,
    output logic [ADDR_W-1:0]   pa,
    output logic [AP_W-1:0]     ap,
    output logic                cacheable,
    output logic                bufferable
);
    localparam int unsigned SEL_W = $clog2(AP_SLOTS);

    logic [AP_W-1:0]  ap_slot [AP_SLOTS];
    logic [SEL_W-1:0] slot_sel;

    // Slice the four per-quarter permission fields.
    for (genvar g = 0; g < AP_SLOTS; g++) begin : g_ap
        assign ap_slot[g] = desc[AP_LSB + AP_W*g +: AP_W];
    end

    // Classify the descriptor by its two type bits.
    always_comb begin
        unique case (desc[1:0])
            2'b01:   kind = L2_LARGE;
            2'b10:   kind = L2_SMALL;
            default: kind = L2_FAULT;
        endcase
    end

    // Form the address and pick the quarter's permission by page size.
    always_comb begin
        if (kind == L2_LARGE) begin
            pa       = {desc[ADDR_W-1:LARGE_SH], va_low};
            slot_sel = va_low[LARGE_SH-1 -: SEL_W];
        end else begin
            pa       = {desc[ADDR_W-1:SMALL_SH], va_low[SMALL_SH-1:0]};
            slot_sel = va_low[SMALL_SH-1 -: SEL_W];
        end
        ap         = ap_slot[slot_sel];
        cacheable  = desc[3];
        bufferable = desc[2];
    end
endmodule

// File: rtl/mmu_walk_ctrl.sv
// Module: walk sequencer. Accepts a request, issues the first- and
// second-level reads one at a time, registers the result and holds it
// until taken. Assumes read data returns at least one cycle after the
// read is accepted, and only for reads this block issued.
module mmu_walk_ctrl
    import mmu_walk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:14] ttb_hi,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_va,
    output logic               req_ready,
    output logic               mem_rd_en,
    input  logic               mem_rd_ready,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  l1_kind_t           l1_kind,
    input  walk_result_t       l1_sect,
    input  logic [ADDR_W-1:0]  l1_l2_addr,
    input  l2_kind_t           l2_kind,
    input  logic [ADDR_W-1:0]  l2_pa,
    input  logic [AP_W-1:0]    l2_ap,
    input  logic               l2_cacheable,
    input  logic               l2_bufferable,
    output logic               res_valid,
    input  logic               res_ready,
    output walk_result_t       res,
    output logic [ADDR_W-1:0]  va_q,
    output logic               in_l2
);
    walk_state_t       state;
    logic              issued;
    logic [ADDR_W-1:0] l2_addr_q;
    logic [DOM_W-1:0]  dom_q;
    walk_result_t      fault_l1_r, fault_l2_r, page_r;

    // Build the candidate results for faults and pages.
    always_comb begin
        fault_l1_r          = '0;
        fault_l1_r.fault    = 1'b1;
        fault_l2_r          = '0;
        fault_l2_r.fault    = 1'b1;
        fault_l2_r.fault_l2 = 1'b1;
        page_r.fault        = 1'b0;
        page_r.fault_l2     = 1'b0;
        page_r.pa           = l2_pa;
        page_r.cacheable    = l2_cacheable;
        page_r.bufferable   = l2_bufferable;
        page_r.domain       = dom_q;
        page_r.ap           = l2_ap;
    end

    // Drive the read port and the handshake flags from the state.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        res_valid   = (state == ST_DONE);
        in_l2       = (state == ST_L2_READ);
        mem_rd_en   = ((state == ST_L1_READ) || (state == ST_L2_READ)) && !issued;
        mem_rd_addr = in_l2 ? l2_addr_q
                            : {ttb_hi, va_q[ADDR_W-1:SECT_SH], 2'b00};
    end

    // Advance the walk and capture the descriptors' results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            issued    <= 1'b0;
            va_q      <= '0;
            l2_addr_q <= '0;
            dom_q     <= '0;
            res       <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_va;
                        issued <= 1'b0;
                        state  <= ST_L1_READ;
                    end
                end
                ST_L1_READ: begin
                    if (mem_rd_en && mem_rd_ready) issued <= 1'b1;
                    if (issued && mem_rd_valid) begin
                        issued <= 1'b0;
                        unique case (l1_kind)
                            L1_SECTION: begin
                                res   <= l1_sect;
                                state <= ST_DONE;
                            end
                            L1_TABLE: begin
                                l2_addr_q <= l1_l2_addr;
                                dom_q     <= l1_sect.domain;
                                state     <= ST_L2_READ;
                            end
                            default: begin
                                res   <= fault_l1_r;
                                state <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_L2_READ: begin
                    if (mem_rd_en && mem_rd_ready) issued <= 1'b1;
                    if (issued && mem_rd_valid) begin
                        issued <= 1'b0;
                        res    <= (l2_kind == L2_FAULT) ? fault_l2_r : page_r;
                        state  <= ST_DONE;
                    end
                end
                default: begin
                    if (res_ready) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/mmu_walker.sv
// Module: top of the two-level translation table walker. Joins the
// sequencer with the two descriptor decoders, which both look at the
// read data. Assumes ttb is held stable while a walk is running.
module mmu_walker
    import mmu_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ttb,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_va,
    output logic              mem_rd_en,
    input  logic              mem_rd_ready,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic              res_fault_l2,
    output logic [31:0]       res_pa,
    output logic              res_cacheable,
    output logic              res_bufferable,
    output logic [3:0]        res_domain,
    output logic [1:0]        res_ap,
    output logic [31:0]       res_va
);
    l1_kind_t          l1_kind;
    walk_result_t      l1_sect;
    logic [ADDR_W-1:0] l1_l2_addr;
    l2_kind_t          l2_kind;
    logic [ADDR_W-1:0] l2_pa;
    logic [AP_W-1:0]   l2_ap;
    logic              l2_c, l2_b;
    walk_result_t      res;
    logic [ADDR_W-1:0] va_q;
    logic              in_l2;
    logic [13:0]       unused_ttb;

    assign unused_ttb = ttb[13:0];

    mmu_l1_decode u_l1 (
        .desc    (mem_rd_data),
        .va_low  (va_q[SECT_SH-1:0]),
        .kind    (l1_kind),
        .sect    (l1_sect),
        .l2_addr (l1_l2_addr)
    );

    mmu_l2_decode u_l2 (
        .desc       (mem_rd_data),
        .va_low     (va_q[LARGE_SH-1:0]),
        .kind       (l2_kind),
        .pa         (l2_pa),
        .ap         (l2_ap),
        .cacheable  (l2_c),
        .bufferable (l2_b)
    );

    mmu_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ttb_hi        (ttb[31:14]),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .req_ready     (req_ready),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rd_valid  (mem_rd_valid),
        .l1_kind       (l1_kind),
        .l1_sect       (l1_sect),
        .l1_l2_addr    (l1_l2_addr),
        .l2_kind       (l2_kind),
        .l2_pa         (l2_pa),
        .l2_ap         (l2_ap),
        .l2_cacheable  (l2_c),
        .l2_bufferable (l2_b),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res           (res),
        .va_q          (va_q),
        .in_l2         (in_l2)
    );

    // Unpack the registered result onto the ports.
    always_comb begin
        res_fault      = res.fault;
        res_fault_l2   = res.fault_l2;
        res_pa         = res.pa;
        res_cacheable  = res.cacheable;
        res_bufferable = res.bufferable;
        res_domain     = res.domain;
        res_ap         = res.ap;
        res_va         = va_q;
    end
endmodule

// File: rtl/mmu_walker_checks.sv
// Module: protocol and result checks for mmu_walker, attached by bind.
// Assumes ttb is stable during a walk.
module mmu_walker_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ttb,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_en,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        res_valid,
    input logic        res_ready,
    input logic        res_fault,
    input logic [31:0] res_pa,
    input logic        res_cacheable,
    input logic        res_bufferable,
    input logic [3:0]  res_domain,
    input logic [1:0]  res_ap,
    input logic [31:0] res_va,
    input logic        in_l2
);
    logic [1:0] reads_in_walk;

    // Count the reads accepted since the last request was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                       reads_in_walk <= '0;
        else if (req_valid && req_ready)  reads_in_walk <= '0;
        else if (mem_rd_en && mem_rd_ready && reads_in_walk != 2'd3)
            reads_in_walk <= reads_in_walk + 2'd1;
    end

    assert_l1_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !in_l2) |-> (mem_rd_addr == {ttb[31:14], res_va[31:20], 2'b00}));

    assert_read_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_rd_ready) |-> (reads_in_walk < 2'd2));

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_pa[11:0] == res_va[11:0]));

    assert_fault_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pa == 32'd0 && res_ap == 2'd0 &&
                                      res_domain == 4'd0 && !res_cacheable && !res_bufferable));

    assert_busy_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa) && $stable(res_ap) &&
                                       $stable(res_fault) && $stable(res_domain)));

    assert_no_read_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !mem_rd_en);
endmodule

bind mmu_walker mmu_walker_checks u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ttb            (ttb),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_ready   (mem_rd_ready),
    .mem_rd_addr    (mem_rd_addr),
    .res_valid      (res_valid),
    .res_ready      (res_ready),
    .res_fault      (res_fault),
    .res_pa         (res_pa),
    .res_cacheable  (res_cacheable),
    .res_bufferable (res_bufferable),
    .res_domain     (res_domain),
    .res_ap         (res_ap),
    .res_va         (res_va),
    .in_l2          (in_l2)
);

// File: tb/sim_mmu_walker.sv
// Bench: random and directed walks against a word memory model that
// accepts at once and answers one cycle later.
module sim_mmu_walker;
    import mmu_walk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ttb = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        mem_rd_en;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic        res_fault, res_fault_l2, res_cacheable, res_bufferable;
    logic [31:0] res_pa, res_va;
    logic [3:0]  res_domain;
    logic [1:0]  res_ap;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    logic [31:0] mem_q [logic [31:0]];
    logic [31:0] rd_log [4];
    int unsigned rd_count = 0;

    always #2 clk = ~clk;

    mmu_walker u0 (.*);

    // Memory model: accept every read, return data one cycle later.
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_en && mem_rd_ready) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem_q.exists(mem_rd_addr) ? mem_q[mem_rd_addr] : 32'd0;
            rd_log[rd_count % 4] <= mem_rd_addr;
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference translation written from the requirements.
    function automatic walk_result_t ref_walk(input logic [31:0] l1, input logic [31:0] l2,
                                              input logic [31:0] va, output int nrd);
        walk_result_t r = '0;
        int k;
        nrd = 1;
        if (l1[1:0] == 2'b10) begin
            r.pa = (l1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
            r.ap = l1[11:10]; r.cacheable = l1[3]; r.bufferable = l1[2];
            r.domain = l1[8:5];
        end else if (l1[1:0] == 2'b01) begin
            nrd = 2;
            if (l2[1:0] == 2'b01) begin
                r.pa = (l2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
                k = int'(va[15:14]);
            end else if (l2[1:0] == 2'b10) begin
                r.pa = (l2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
                k = int'(va[11:10]);
            end else begin
                r.fault = 1'b1; r.fault_l2 = 1'b1; k = -1;
            end
            if (k >= 0) begin
                r.ap = 2'((l2 >> (4 + 2*k)) & 32'h3);
                r.cacheable = l2[3]; r.bufferable = l2[2];
                r.domain = l1[8:5];
            end
        end else begin
            r.fault = 1'b1;
        end
        return r;
    endfunction

    // One walk: load tables, request, time and check the result.
    task automatic walk(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] l1, input logic [31:0] l2);
        walk_result_t e;
        int nrd, lat, hold;
        int unsigned start;
        logic [31:0] a1, a2;
        e  = ref_walk(l1, l2, va, nrd);
        a1 = {base[31:14], va[31:20], 2'b00};
        a2 = {l1[31:10], va[19:12], 2'b00};
        mem_q.delete();
        mem_q[a1] = l1;
        if (nrd == 2) mem_q[a2] = l2;
        @(negedge clk);
        ttb = base; req_va = va; req_valid = 1'b1;
        start = rd_count;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!res_valid) begin
            @(negedge clk);
            lat++;
        end
        check(lat == nrd * 2, "R10 latency", lat, nrd * 2);
        check(rd_count - start == nrd, "R2 read count", rd_count - start, nrd);
        check(rd_log[start % 4] == a1, "R1 first read address", rd_log[start % 4], a1);
        if (nrd == 2)
            check(rd_log[(start + 1) % 4] == a2, "R4 second read address", rd_log[(start + 1) % 4], a2);
        check(res_fault == e.fault && res_fault_l2 == e.fault_l2, "R2/R7 fault flags",
              {30'd0, res_fault, res_fault_l2}, {30'd0, e.fault, e.fault_l2});
        check(res_pa == e.pa, "R3/R5/R6 physical address", res_pa, e.pa);
        check(res_ap == e.ap, "R5/R6 permission field", res_ap, e.ap);
        check(res_domain == e.domain, "R8 domain", res_domain, e.domain);
        check(res_cacheable == e.cacheable && res_bufferable == e.bufferable, "R8 attributes",
              {30'd0, res_cacheable, res_bufferable}, {30'd0, e.cacheable, e.bufferable});
        check(res_va == va, "R7 returned va", res_va, va);
        hold = $urandom_range(3, 0);
        for (int i = 0; i < hold; i++) @(negedge clk);
        check(res_valid && res_pa == e.pa && !req_ready, "R9 result held", res_pa, e.pa);
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_ready = 1'b0;
        check(req_ready && !res_valid, "R9 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] rand_base();
        return {1'b1, 17'($urandom()), 14'd0};
    endfunction

    initial begin
        logic [31:0] l1, l2, base, va;
        int pick;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready && !res_valid && !mem_rd_en, "R9 reset state", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;

        // Directed: section with every attribute bit and a low base bit set (R1, R3).
        walk(32'h8000_7FFF & 32'hFFFF_FFFF, 32'hABCD_1234, 32'h5A50_0DEE, 32'd0);
        // Directed: first-level faults 00 and 11 (R2, R7).
        walk(32'h8001_C000, 32'h1234_5678, 32'hFFFF_FFFC, 32'd0);
        walk(32'h8001_C000, 32'h1234_5678, 32'hFFFF_FFFF, 32'd0);
        // Directed: large page, each quarter (R5).
        for (int q = 0; q < 4; q++)
            walk(32'h8004_0000, {16'h4321, 2'(q), 14'h0ABC}, 32'h0012_3421, 32'hBEEF_E4D5);
        // Directed: small page, each quarter (R6).
        for (int q = 0; q < 4; q++)
            walk(32'h8004_0000, {20'h77654, 2'(q), 10'h155}, 32'h0012_3521, 32'hCAFE_11B6);
        // Directed: second-level faults 00 and 11 (R7).
        walk(32'h8008_0000, 32'h0000_F000, 32'h0000_4001, 32'hFFFF_FFFC);
        walk(32'h8008_0000, 32'h0000_F000, 32'h0000_4001, 32'hFFFF_FFFF);

        // Random walks.
        for (int n = 0; n < 300; n++) begin
            base = rand_base();
            va   = $urandom();
            l1   = $urandom();
            l2   = $urandom();
            pick = $urandom_range(7, 0);
            if (pick == 0)      l1[1:0] = 2'b00;
            else if (pick == 1) l1[1:0] = 2'b11;
            else if (pick < 4)  l1[1:0] = 2'b10;
            else begin
                l1[31]  = 1'b0;
                l1[1:0] = 2'b01;
            end
            walk(base, va, l1, l2);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung walk counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule